// File: doc/BRIEF.md
# Serial Programming Target Controller

This block is the device-side end of a two-wire program/verify link for a small flash array of 12-bit words. An external programmer toggles a slow programming clock and a shared data line; the controller brings both into the fast system clock domain through two-flop synchronizers, finds the clock edges there, and assembles 6-bit commands and 16-clock data frames. A behavioural array of 1024 words stands in for the flash: the lower half is user program space and the upper half is configuration space, with the configuration word in its top location.

A single mode-enable input stands for high-voltage entry. While it is low, the serial engine and the address counter are held at their entry state; the array keeps its contents and is reset to all ones only by the system reset. Programming and erase finish after fixed counts of system cycles. Programming is a bitwise AND into the old contents, since no erase is done, and bulk erase covers more or less of the array depending on where the address counter stands when the command arrives.

Top module: `spt_target`

## Requirements
- R1: A command is six bits, each taken at a falling edge of the programming clock, first bit least significant; the upper two bits are ignored.
- R2: The low four command bits decode as: 0010 load, 0100 read, 0110 increment, 1000 begin programming, 1110 end programming, 1001 bulk erase; any other code leaves address, load state and memory unchanged.
- R3: A load is followed by 16 falling edges: edge 1 is a start bit and edge 16 a stop bit, both ignored; edges 2 to 15 carry 14 data bits least significant first, of which the top two are discarded.
- R4: A read returns, in the same 16-clock frame, the word at the current address with the top two of the 14 data bits as 0.
- R5: During a read the data output is enabled from the second rising clock edge of the frame until the sixteenth rising edge, and is disabled at all other times.
- R6: On mode entry the address is 0x3FF and the configuration word is readable and programmable there; after any increment, address 0x3FF reads 0 and programming there has no effect until the next entry.
- R7: Increment goes 0x1FF to 0x200 and 0x3FF to 0x000; the address never decrements.
- R8: When configuration word bit 3 is 0, reads of 0x040 to 0x1FE return 0; 0x000 to 0x03F, 0x1FF, 0x200 to 0x204 and the configuration word always read their contents.
- R9: A bulk erase issued at any address other than 0x200 sets all of 0x000 to 0x1FF and the configuration word to all ones and keeps 0x200 to 0x204.
- R10: A bulk erase issued at address 0x200 sets every location, 0x200 to 0x204 included, to all ones.
- R11: Begin programming writes old AND loaded into the current address and consumes the load; a begin with no load since the last one writes nothing and sets a sticky error flag.
- R12: Dropping mode-enable clears the error flag and returns the address to entry state while memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Program/verify mode active |
| prog_clk | input | 1 | Programming clock from the external programmer (asynchronous) |
| prog_dat_in | input | 1 | Data line as seen at the pad input |
| prog_dat_out | output | 1 | Data line value driven during reads |
| prog_dat_oe | output | 1 | Output enable for the data line |
| prog_err | output | 1 | Sticky flag: begin programming without a prior load |

## Verification
A wrong address counter shows at the next read as a word from the wrong location, or as a non-zero value where the hidden configuration word should read 0, within one command frame; walking the counter across 0x1FF and 0x3FF exposes wrap faults. A wrong protection decode or erase scope shows as a read of a word that was programmed with a known random value, so each such fault surfaces at the first read of an affected address. A mis-timed output enable is caught on the very read frame it occurs in, because the enable is sampled at every data clock.

// File: rtl/spt_pkg.sv
package spt_pkg;
  typedef enum logic [3:0] {
    OP_LOAD  = 4'b0010,
    OP_READ  = 4'b0100,
    OP_INC   = 4'b0110,
    OP_BEGIN = 4'b1000,
    OP_END   = 4'b1110,
    OP_ERASE = 4'b1001
  } op_e;

  typedef enum logic [1:0] {PH_CMD, PH_LOAD, PH_READ} phase_e;

  typedef enum logic [1:0] {PEND_NONE, PEND_WRITE, PEND_ERASE_STD, PEND_ERASE_ALL} pend_e;
endpackage

// File: rtl/spt_sync.sv
module spt_sync #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta;
    logic stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= 1'b0;
        stab <= 1'b0;
      end else begin
        meta <= d[i];
        stab <= meta;
      end
    end
    assign q[i] = stab;
  end
endmodule

// File: rtl/spt_serial.sv
module spt_serial
  import spt_pkg::*;
#(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic [WORD_W-1:0] rd_word,
  output logic              cmd_v,
  output logic [3:0]        cmd_op,
  output logic              ld_v,
  output logic [WORD_W-1:0] ld_word,
  output logic              dout,
  output logic              doe
);
  localparam int unsigned FRAME_W = WORD_W + 2;
  localparam int unsigned IDX_W   = $clog2(FRAME_W);

  logic               sclk_q;
  phase_e             phase, phase_n;
  logic [4:0]         fcnt, fcnt_n, rcnt, rcnt_n;
  logic [4:0]         csh, csh_n;
  logic [FRAME_W-1:0] dsh, dsh_n, rd_lat, rd_n;
  logic               dout_n, doe_n;
  logic               rise, fall;
  logic [5:0]         cbits;
  logic [IDX_W-1:0]   oidx;

  assign rise    = sclk_s & ~sclk_q;
  assign fall    = ~sclk_s & sclk_q;
  assign cbits   = {sdat_s, csh};
  assign cmd_op  = cbits[3:0];
  assign ld_word = dsh[WORD_W-1:0];
  assign oidx    = IDX_W'(rcnt - 5'd1);

  always_comb begin
    phase_n = phase;
    fcnt_n  = fcnt;
    rcnt_n  = rcnt;
    csh_n   = csh;
    dsh_n   = dsh;
    rd_n    = rd_lat;
    dout_n  = dout;
    doe_n   = doe;
    cmd_v   = 1'b0;
    ld_v    = 1'b0;
    case (phase)
      PH_CMD: begin
        if (fall) begin
          csh_n = cbits[5:1];
          if (fcnt == 5'd5) begin
            fcnt_n = 5'd0;
            cmd_v  = 1'b1;
            if (cbits[3:0] == OP_LOAD) begin
              phase_n = PH_LOAD;
            end else if (cbits[3:0] == OP_READ) begin
              phase_n = PH_READ;
              rcnt_n  = 5'd0;
              rd_n    = {2'b00, rd_word};
            end
          end else begin
            fcnt_n = fcnt + 5'd1;
          end
        end
      end
      PH_LOAD: begin
        if (fall) begin
          if (fcnt >= 5'd1 && fcnt <= 5'd14) dsh_n = {sdat_s, dsh[FRAME_W-1:1]};
          if (fcnt == 5'd15) begin
            ld_v    = 1'b1;
            phase_n = PH_CMD;
            fcnt_n  = 5'd0;
          end else begin
            fcnt_n = fcnt + 5'd1;
          end
        end
      end
      default: begin
        if (rise) begin
          rcnt_n = rcnt + 5'd1;
          if (rcnt >= 5'd1 && rcnt <= 5'd14) begin
            doe_n  = 1'b1;
            dout_n = rd_lat[oidx];
          end else if (rcnt == 5'd15) begin
            doe_n  = 1'b0;
            dout_n = 1'b0;
          end
        end
        if (fall) begin
          if (fcnt == 5'd15) begin
            phase_n = PH_CMD;
            fcnt_n  = 5'd0;
          end else begin
            fcnt_n = fcnt + 5'd1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      phase  <= PH_CMD;
      fcnt   <= '0;
      rcnt   <= '0;
      csh    <= '0;
      dsh    <= '0;
      rd_lat <= '0;
      dout   <= 1'b0;
      doe    <= 1'b0;
    end else if (!en) begin
      sclk_q <= sclk_s;
      phase  <= PH_CMD;
      fcnt   <= '0;
      rcnt   <= '0;
      csh    <= '0;
      dsh    <= '0;
      rd_lat <= '0;
      dout   <= 1'b0;
      doe    <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      phase  <= phase_n;
      fcnt   <= fcnt_n;
      rcnt   <= rcnt_n;
      csh    <= csh_n;
      dsh    <= dsh_n;
      rd_lat <= rd_n;
      dout   <= dout_n;
      doe    <= doe_n;
    end
  end

  // R5: the line is only driven inside a read frame
  assert_doe_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    doe |-> phase == PH_READ);
  // R5: drive starts on the second rising clock of the frame
  assert_doe_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doe) |-> $past(rise) && $past(rcnt) == 5'd1);
  // R5: drive ends at a rising clock or on mode exit
  assert_doe_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(doe) |-> $past(rise) || $past(!en));
endmodule

// File: rtl/spt_core.sv
module spt_core
  import spt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned WORD_W    = 12,
  parameter int unsigned PROG_CYC  = 20,
  parameter int unsigned ERASE_CYC = 40,
  parameter int unsigned PROT_LO   = 64,
  parameter int unsigned CP_BIT    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cmd_v,
  input  logic [3:0]        cmd_op,
  input  logic              ld_v,
  input  logic [WORD_W-1:0] ld_word,
  output logic [WORD_W-1:0] rd_word,
  output logic              err
);
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned HALF   = DEPTH / 2;
  localparam int unsigned MAXC   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned TMR_W  = $clog2(MAXC + 1);
  localparam logic [ADDR_W-1:0] CFG_A  = '1;
  localparam logic [ADDR_W-1:0] ID0_A  = ADDR_W'(HALF);
  localparam logic [ADDR_W-1:0] UTOP_A = ADDR_W'(HALF - 1);
  localparam logic [ADDR_W-1:0] PLO_A  = ADDR_W'(PROT_LO);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] pc, pc_n, tgt, tgt_n;
  logic              vis, vis_n, loaded, loaded_n, err_n;
  logic [WORD_W-1:0] ldat, ldat_n;
  logic [TMR_W-1:0]  tmr, tmr_n;
  pend_e             pend, pend_n;
  logic              commit, cp_on;

  assign cp_on  = ~mem[CFG_A][CP_BIT];
  assign commit = (pend != PEND_NONE) && (tmr == '0);

  always_comb begin
    if (pc == CFG_A)
      rd_word = vis ? mem[CFG_A] : '0;
    else if (cp_on && pc >= PLO_A && pc < UTOP_A)
      rd_word = '0;
    else
      rd_word = mem[pc];
  end

  always_comb begin
    pc_n     = pc;
    vis_n    = vis;
    loaded_n = loaded;
    ldat_n   = ldat;
    err_n    = err;
    tmr_n    = tmr;
    pend_n   = pend;
    tgt_n    = tgt;
    if (pend != PEND_NONE) begin
      if (tmr == '0) pend_n = PEND_NONE;
      else           tmr_n  = tmr - 1'b1;
    end
    if (ld_v) begin
      ldat_n   = ld_word;
      loaded_n = 1'b1;
    end
    if (cmd_v) begin
      case (cmd_op)
        OP_INC: begin
          pc_n  = pc + 1'b1;
          vis_n = 1'b0;
        end
        OP_BEGIN: begin
          if (!loaded) begin
            err_n = 1'b1;
          end else begin
            loaded_n = 1'b0;
            pend_n   = PEND_WRITE;
            tmr_n    = TMR_W'(PROG_CYC - 1);
            tgt_n    = pc;
          end
        end
        OP_ERASE: begin
          pend_n = (pc == ID0_A) ? PEND_ERASE_ALL : PEND_ERASE_STD;
          tmr_n  = TMR_W'(ERASE_CYC - 1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= CFG_A;
      vis    <= 1'b1;
      loaded <= 1'b0;
      ldat   <= '0;
      err    <= 1'b0;
      tmr    <= '0;
      pend   <= PEND_NONE;
      tgt    <= '0;
    end else if (!en) begin
      pc     <= CFG_A;
      vis    <= 1'b1;
      loaded <= 1'b0;
      ldat   <= '0;
      err    <= 1'b0;
      tmr    <= '0;
      pend   <= PEND_NONE;
      tgt    <= '0;
    end else begin
      pc     <= pc_n;
      vis    <= vis_n;
      loaded <= loaded_n;
      ldat   <= ldat_n;
      err    <= err_n;
      tmr    <= tmr_n;
      pend   <= pend_n;
      tgt    <= tgt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (en && commit) begin
      case (pend)
        PEND_WRITE: begin
          if (!(tgt == CFG_A && !vis)) mem[tgt] <= mem[tgt] & ldat;
        end
        PEND_ERASE_STD: begin
          for (int i = 0; i < HALF; i++) mem[i] <= '1;
          mem[CFG_A] <= '1;
        end
        PEND_ERASE_ALL: begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end
        default: ;
      endcase
    end
  end

  // R6: the configuration word is hidden only by an increment
  assert_cfg_hide_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vis) |-> $past(cmd_v) && $past(cmd_op) == OP_INC);
  // R12: every mode entry starts at the configuration word
  assert_entry_pc_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> pc == CFG_A && vis && !err);
  // R11: the error flag stays set for the rest of the session
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n || !en)
    err |=> err);
  // R9: no operation counter ever exceeds its longest load value
  assert_tmr_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmr <= TMR_W'(MAXC));
endmodule

// File: rtl/spt_target.sv
module spt_target #(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned WORD_W    = 12,
  parameter int unsigned PROG_CYC  = 20,
  parameter int unsigned ERASE_CYC = 40,
  parameter int unsigned PROT_LO   = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_en,
  input  logic prog_clk,
  input  logic prog_dat_in,
  output logic prog_dat_out,
  output logic prog_dat_oe,
  output logic prog_err
);
  logic [1:0]        pins_s;
  logic              cmd_v, ld_v;
  logic [3:0]        cmd_op;
  logic [WORD_W-1:0] ld_word, rd_word;

  spt_sync #(.WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({prog_clk, prog_dat_in}),
    .q     (pins_s)
  );

  spt_serial #(.WORD_W(WORD_W)) u_serial (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (mode_en),
    .sclk_s  (pins_s[1]),
    .sdat_s  (pins_s[0]),
    .rd_word (rd_word),
    .cmd_v   (cmd_v),
    .cmd_op  (cmd_op),
    .ld_v    (ld_v),
    .ld_word (ld_word),
    .dout    (prog_dat_out),
    .doe     (prog_dat_oe)
  );

  spt_core #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC),
    .PROT_LO   (PROT_LO)
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (mode_en),
    .cmd_v   (cmd_v),
    .cmd_op  (cmd_op),
    .ld_v    (ld_v),
    .ld_word (ld_word),
    .rd_word (rd_word),
    .err     (prog_err)
  );
endmodule

// File: tb/sim_spt_target.sv
`timescale 1ns/1ps
module sim_spt_target;
  localparam int H     = 4;
  localparam int PWAIT = 40;
  localparam int EWAIT = 100;
  localparam logic [3:0] C_LOAD = 4'b0010, C_READ = 4'b0100, C_INC = 4'b0110,
                         C_BEG = 4'b1000, C_END = 4'b1110, C_ERASE = 4'b1001;
  localparam logic [9:0] CFG = 10'h3FF;

  logic clk, rst_n, mode_en, prog_clk, prog_dat_in;
  logic prog_dat_out, prog_dat_oe, prog_err;

  int unsigned n_chk, n_err;
  bit          done;
  logic [11:0] exp_mem [1024];
  logic [9:0]  pc_m;
  bit          vis_m;

  spt_target u0 (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .prog_clk(prog_clk),
    .prog_dat_in(prog_dat_in), .prog_dat_out(prog_dat_out),
    .prog_dat_oe(prog_dat_oe), .prog_err(prog_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [11:0] exp_rd();
    if (pc_m == CFG) return vis_m ? exp_mem[CFG] : 12'h000;
    if (!exp_mem[CFG][3] && pc_m >= 10'h040 && pc_m <= 10'h1FE) return 12'h000;
    return exp_mem[pc_m];
  endfunction

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      prog_dat_in = v[i];
      prog_clk = 1'b1; tick(H);
      prog_clk = 1'b0; tick(H);
    end
  endtask

  task automatic send_cmd(input logic [3:0] op);
    send_bits({10'd0, 2'($urandom), op}, 6);
    tick(2);
  endtask

  task automatic load_word(input logic [11:0] w);
    send_cmd(C_LOAD);
    send_bits({1'($urandom), 2'($urandom), w, 1'($urandom)}, 16);
    tick(2);
  endtask

  task automatic do_read(output logic [13:0] got, output logic oe_ok);
    got = '0;
    oe_ok = 1'b1;
    send_cmd(C_READ);
    for (int k = 0; k < 16; k++) begin
      prog_dat_in = 1'($urandom);
      prog_clk = 1'b1; tick(H);
      if (k >= 1 && k <= 14) begin
        got[k-1] = prog_dat_out;
        if (prog_dat_oe !== 1'b1) oe_ok = 1'b0;
      end else if (prog_dat_oe !== 1'b0) oe_ok = 1'b0;
      prog_clk = 1'b0; tick(H);
      if (k == 15 && prog_dat_oe !== 1'b0) oe_ok = 1'b0;
    end
    tick(2);
  endtask

  task automatic check_rd(input string tag);
    logic [13:0] got;
    logic ok;
    do_read(got, ok);
    check(tag, {2'b00, got}, {4'h0, exp_rd()});
    check("R5 output enable window", {15'd0, ok}, 16'd1);
  endtask

  task automatic prog_word(input logic [11:0] w);
    load_word(w);
    send_cmd(C_BEG);
    tick(PWAIT);
    send_cmd(C_END);
    if (!(pc_m == CFG && !vis_m)) exp_mem[pc_m] &= w;
  endtask

  task automatic inc1();
    send_cmd(C_INC);
    pc_m = pc_m + 10'd1;
    vis_m = 1'b0;
  endtask

  task automatic inc_to(input logic [9:0] a);
    while (pc_m != a) inc1();
  endtask

  task automatic reenter();
    mode_en = 1'b0; tick(4);
    check("R12 error cleared on exit", {15'd0, prog_err}, 16'd0);
    mode_en = 1'b1; tick(4);
    pc_m = CFG;
    vis_m = 1'b1;
  endtask

  task automatic bulk_erase();
    bit all;
    all = (pc_m == 10'h200);
    send_cmd(C_ERASE);
    tick(EWAIT);
    for (int i = 0; i < 1024; i++)
      if (all || i < 512 || i == 1023) exp_mem[i] = 12'hFFF;
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 0;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 1024; i++) exp_mem[i] = 12'hFFF;
    rst_n = 1'b0; mode_en = 1'b0; prog_clk = 1'b0; prog_dat_in = 1'b0;
    pc_m = CFG; vis_m = 1'b1;
    tick(5);
    check("R5 reset output enable", {15'd0, prog_dat_oe}, 16'd0);
    check("R11 reset error flag", {15'd0, prog_err}, 16'd0);
    rst_n = 1'b1; tick(3);
    mode_en = 1'b1; tick(4);

    check_rd("R6 config word visible at entry");
    inc1();
    for (int i = 0; i < 4; i++) begin
      prog_word(12'($urandom));
      check_rd("R3 R4 R1 load then read back");
      if (i < 3) inc1();
    end
    prog_word(12'($urandom));
    check_rd("R11 second program ANDs into old value");
    send_cmd(C_BEG);
    tick(PWAIT);
    check("R11 begin without load flags error", {15'd0, prog_err}, 16'd1);
    check_rd("R11 begin without load writes nothing");
    send_cmd(4'b0000);
    send_cmd(4'b1111);
    tick(PWAIT);
    check_rd("R2 unknown codes have no effect");

    inc_to(10'h03F); prog_word(12'($urandom)); check_rd("R4 word at 0x03F");
    inc1();          prog_word(12'($urandom)); check_rd("R4 word at 0x040");
    inc_to(10'h1FF); prog_word(12'($urandom)); check_rd("R4 word at 0x1FF");
    inc1();
    check_rd("R7 0x1FF steps to user ID 0x200");
    prog_word({8'hFF, 4'($urandom)});
    check_rd("R4 user ID programmed");
    inc_to(10'h204); prog_word(12'($urandom)); check_rd("R4 backup word programmed");
    inc_to(CFG);
    check_rd("R6 config word hidden after increment");
    prog_word(12'h000);
    check_rd("R6 hidden config word not programmed");
    inc1();
    check_rd("R7 0x3FF wraps to 0x000");

    reenter();
    check_rd("R12 memory kept, config untouched by hidden write");
    prog_word(12'hFF7);
    check_rd("R6 config word programmed, protection on");
    inc1();          check_rd("R8 0x000 unprotected");
    inc_to(10'h03F); check_rd("R8 0x03F unprotected");
    inc1();          check_rd("R8 0x040 reads zero");
    inc_to(10'h1FE); check_rd("R8 0x1FE reads zero");
    inc1();          check_rd("R8 0x1FF unprotected");
    inc1();          check_rd("R8 user ID unprotected");
    inc_to(10'h204); check_rd("R8 backup word unprotected");

    reenter();
    bulk_erase();
    check_rd("R9 config word erased");
    inc1();          check_rd("R9 user word erased");
    inc_to(10'h1FF); check_rd("R9 last user word erased");
    inc1();          check_rd("R9 user ID kept");
    inc_to(10'h204); check_rd("R9 backup word kept");

    reenter();
    inc_to(10'h200);
    bulk_erase();
    check_rd("R10 user ID erased");
    inc_to(10'h204); check_rd("R10 backup word erased");

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule